// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs the digital half of a 10-bit successive-approximation conversion. After a start request it presents a trial code to an external capacitive DAC. On each cycle in which the conversion-clock enable is high it reads one comparator decision and resolves one bit, working from the most significant bit down to the least. Once the last bit is resolved it raises a one-cycle done strobe and publishes the formatted result. The result then holds until the next conversion finishes.

Result coding depends on two mode inputs, which are sampled when a conversion starts. Unipolar coding produces straight binary from 0 to full scale. Bipolar coding produces two's complement over plus and minus half the reference. Single-ended operation always uses unipolar coding, whatever the bipolar select says. The DAC, the comparator and the track/hold are outside this block. The comparator input `cmpKeep` must be 1 when the sampled analog level is at or above the level of the current trial code.

Top module: `sar_seq`

## Requirements
- R1: After reset `busy` and `done` are 0 and `result` is 0.
- R2: A `start` seen while idle makes `busy` 1 on the next clock edge, with `trial` equal to 0x200 (only bit 9 set).
- R3: A conversion takes exactly 10 clock edges on which `convEn` is 1. Edges with `convEn` low leave `trial` unchanged.
- R4: `done` is a one-cycle pulse. It rises on the same edge where `busy` falls, which is the edge of the tenth enabled decision.
- R5: In unipolar coding, `result` is the straight-binary value of the input in LSB units over 0..1023. Inputs above full scale give 1023.
- R6: In unipolar coding, a negative input gives `result` = 0.
- R7: In bipolar coding (`seMode`=0, `bipSel`=1), `result` is the 10-bit two's complement of the input over -512..511. Out-of-range inputs clamp to the nearest end. The DAC trial level is `trial`-512.
- R8: With `seMode`=1 the coding is unipolar even when `bipSel`=1.
- R9: `result` stays unchanged from one `done` pulse until the next.
- R10: A `start` while `busy` is 1 is ignored. The running conversion ends on its original edge with its own result.
- R11: `seMode` and `bipSel` are sampled with the accepted `start`. Changing them during a conversion does not affect it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request, acted on only when idle |
| convEn | input | 1 | Conversion-clock enable, one bit decision per enabled edge |
| cmpKeep | input | 1 | Comparator decision, 1 = input at or above trial level |
| seMode | input | 1 | 1 = single-ended, 0 = differential |
| bipSel | input | 1 | 1 = bipolar coding requested (differential only) |
| trial | output | 10 | Trial code driven to the DAC |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when the result is updated |
| result | output | 10 | Formatted conversion result |

## Verification
`busy` and the first trial code are due one edge after the start edge. The bench drives inputs on falling edges and checks these at the next falling edge. `result` and `done` are due on the edge of the tenth enabled decision. The bench therefore counts only the edges where it held `convEn` high and checks that `done` appears exactly when that count reaches ten, then checks `done` low one edge later. Expected codes come from a clamp-and-encode function of the integer input and the modes latched at start. The comparator model uses those latched modes, so changes to the mode inputs in mid-conversion are seen only as stimulus.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef struct packed {
    logic load;
    logic step;
    logic last;
  } sarStrobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } sarState_t;
endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int W = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       convEn,
  output sarStrobe_t strb,
  output logic       busy,
  output logic       done
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LASTIDX = CW'(W - 1);

  sarState_t state;
  logic [CW-1:0] bitsLeft;

  always_comb begin
    strb.load = (state == ST_IDLE) && start;
    strb.step = (state == ST_CONV) && convEn;
    strb.last = strb.step && (bitsLeft == '0);
  end

  assign busy = (state == ST_CONV);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitsLeft <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (strb.load) begin
        state    <= ST_CONV;
        bitsLeft <= LASTIDX;
      end else if (strb.step) begin
        if (strb.last) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end else begin
          bitsLeft <= bitsLeft - 1'b1;
        end
      end
    end
  end

  // R4: done lasts exactly one cycle
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R4: leaving the busy state always comes with done
  a_r4_done_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
  // R10: a start during conversion does not end or restart it early
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !convEn) |=> (busy && $stable(bitsLeft)));
endmodule

// File: rtl/sar_dpath.sv
module sar_dpath
  import sar_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  sarStrobe_t   strb,
  input  logic         cmpKeep,
  input  logic         seMode,
  input  logic         bipSel,
  output logic [W-1:0] trial,
  output logic [W-1:0] result
);
  localparam logic [W-1:0] TOPBIT = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] mask;
  logic [W-1:0] nextTrial;
  logic [W-1:0] coded;
  logic         bipLat;

  always_comb begin
    nextTrial = (cmpKeep ? trial : (trial & ~mask)) | (mask >> 1);
    coded     = bipLat ? (nextTrial ^ TOPBIT) : nextTrial;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trial  <= '0;
      mask   <= '0;
      bipLat <= 1'b0;
      result <= '0;
    end else if (strb.load) begin
      trial  <= TOPBIT;
      mask   <= TOPBIT;
      bipLat <= bipSel & ~seMode;
    end else if (strb.step) begin
      trial <= nextTrial;
      mask  <= mask >> 1;
      if (strb.last) result <= coded;
    end
  end

  // R3: at most one bit under test at any time
  a_r3_mask_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(mask));
  // R3: trial code frozen on edges without a decision
  a_r3_trial_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.step && !strb.load) |=> $stable(trial));
  // R9: result only moves on the final decision
  a_r9_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.last |=> $stable(result));
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         convEn,
  input  logic         cmpKeep,
  input  logic         seMode,
  input  logic         bipSel,
  output logic [W-1:0] trial,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result
);
  sarStrobe_t strb;

  sar_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .convEn(convEn),
    .strb(strb), .busy(busy), .done(done)
  );

  sar_dpath #(.W(W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .cmpKeep(cmpKeep),
    .seMode(seMode), .bipSel(bipSel), .trial(trial), .result(result)
  );
endmodule

// File: tb/tb_sar_seq.sv
module tb_sar_seq;
  localparam int W = 10;
  localparam time CLKP = 20ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic convEn = 1'b0;
  logic seMode = 1'b1;
  logic bipSel = 1'b0;
  logic cmpKeep;
  logic [W-1:0] trial, result;
  logic busy, done;

  int nChecks = 0;
  int nFails = 0;
  int anaIn = 0;
  bit modelBip = 1'b0;

  always #(CLKP/2) clk = ~clk;

  sar_seq #(.W(W)) dut (
    .clk(clk), .rstN(rstN), .start(start), .convEn(convEn),
    .cmpKeep(cmpKeep), .seMode(seMode), .bipSel(bipSel),
    .trial(trial), .busy(busy), .done(done), .result(result)
  );

  // behavioural comparator: input at or above the DAC trial level
  always_comb begin
    int lvl;
    lvl = modelBip ? (int'(trial) - 512) : int'(trial);
    cmpKeep = (anaIn >= lvl);
  end

  function automatic int expCode(int x, bit se, bit bip);
    int v;
    if (se || !bip) begin
      v = (x < 0) ? 0 : ((x > 1023) ? 1023 : x);
      return v;
    end
    v = (x < -512) ? -512 : ((x > 511) ? 511 : x);
    return v & 1023;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // flags: gaps = random convEn, midStart = start pulses while busy,
  // flip = mode inputs toggled after start
  task automatic runConv(int x, bit se, bit bip, bit gaps, bit midStart,
                         bit flip, string req);
    int en = 0;
    int guard = 0;
    int expv;
    logic [W-1:0] prevTrial;
    bit wasEn;
    anaIn = x;
    seMode = se;
    bipSel = bip;
    modelBip = bip && !se;
    expv = expCode(x, se, bip);
    @(negedge clk);
    start = 1'b1;
    convEn = 1'b0;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R2 busy", int'(busy), 1);
    check(trial === 10'h200, "R2 trial", int'(trial), 512);
    if (flip) begin
      seMode = ~se;
      bipSel = ~bip;
    end
    while (guard < 200) begin
      guard++;
      wasEn = gaps ? (($urandom % 3) != 0) : 1'b1;
      convEn = wasEn;
      if (midStart && en == 4) start = 1'b1;
      prevTrial = trial;
      @(negedge clk);
      start = 1'b0;
      if (wasEn) en++;
      else check(trial === prevTrial, "R3 hold", int'(trial), int'(prevTrial));
      if (done === 1'b1) break;
      check(busy === 1'b1 && en < 10, "R3/R10 still busy", en, 10);
      if (en >= 10) break;
    end
    convEn = 1'b0;
    check(en == 10, "R3 enabled edges", en, 10);
    check(done === 1'b1 && busy === 1'b0, "R4 done with idle",
          int'({done, busy}), 2);
    check(result === expv[W-1:0], req, int'(result), expv);
    @(negedge clk);
    check(done === 1'b0, "R4 done pulse", int'(done), 0);
    check(result === expv[W-1:0], "R9 hold", int'(result), expv);
  endtask

  initial begin
    #(CLKP * 200000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    #(CLKP * 3);
    check(busy === 1'b0 && done === 1'b0, "R1 flags", int'({busy, done}), 0);
    check(result === '0, "R1 result", int'(result), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && result === '0, "R1 after release", int'(result), 0);

    // directed corners
    runConv(0,    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5 zero");
    runConv(1023, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5 full");
    runConv(1500, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5 over");
    runConv(-5,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6 negative");
    runConv(-300, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R6 negative se");
    runConv(-512, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R7 most negative");
    runConv(511,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R7 most positive");
    runConv(0,    1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R7 zero");
    runConv(-1,   1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R7 minus one");
    runConv(-900, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R7 clamp low");
    runConv(-20,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R8 se forces unipolar");
    runConv(700,  1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R8 se high code");
    runConv(345,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R10 start while busy");
    runConv(-77,  1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R11 modes latched bip");
    runConv(600,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R11 modes latched se");

    // constrained random
    for (int i = 0; i < 60; i++) begin
      int x;
      bit se, bip;
      x = int'($urandom % 1400) - 600;
      se = $urandom % 2;
      bip = $urandom % 2;
      runConv(x, se, bip, $urandom % 2, ($urandom % 4) == 0,
              ($urandom % 4) == 0, "R5/R6/R7/R8 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule